// File: doc/BRIEF.md
# Hybrid Static/History Branch Direction Predictor

This block guesses the direction of conditional branches for a front end. A lookup gives the branch address, the branch target and an 8-bit hint code. In the same cycle the block returns a taken/not-taken guess and a flag. The flag tells whether the guess came from recorded history or from the fixed rule.

Resolved branches arrive on a separate update port. Each one carries the branch address, its target and the real outcome. The block keeps a small fully associative table with eight slots. Each slot holds a full-address tag, a 16-position circular outcome record and a read/write position.

A hit replays the record bit at the current position. Because of this, any repeating outcome pattern whose period divides 16 is reproduced exactly once the record is full. A 4-trip loop is one such pattern. On a miss, backward branches are guessed taken and forward branches not taken, unless one of two hint codes forces the direction.

Both ports follow valid/ready rules with ready permanently high. The block never applies back-pressure, so every asserted lookup or update is consumed in its own cycle. `pred_valid` follows `lkp_valid` in the same cycle.

Top module: `bp_hybrid_predictor`

## Requirements
- R1: A synchronous active-high reset empties the table; any lookup afterwards reports `pred_from_hist`=0.
- R2: On a miss with no forcing hint, a branch whose target is greater than its address is predicted not taken.
- R3: On a miss with no forcing hint, a branch whose target is less than or equal to its address is predicted taken.
- R4: On a miss, hint 8'h3E forces taken and hint 8'h2E forces not taken; every other hint value leaves the direction rule in charge.
- R5: On a hit the hint code has no effect on `pred_taken`.
- R6: On a hit, `pred_from_hist`=1 and `pred_taken` equals the slot's record bit at its current position; lookups never change state.
- R7: An update that misses claims a slot. It stores the full address as tag and fills all 16 record bits with the direction-rule result of the update's address and target. It then overwrites bit 0 with the outcome and sets the position to 1.
- R8: An update that hits writes the outcome at the slot's current position. The position then advances by one, wrapping from 15 to 0.
- R9: Slots are claimed in allocation order. Once all eight are in use, a new branch replaces the one allocated earliest.
- R10: When a lookup and an update name the same address in the same cycle, the lookup reports the state after that update.
- R11: `pred_valid` equals `lkp_valid`; with `lkp_valid` low no prediction is presented.
- R12: A backward branch driving a 4-trip loop (taken, taken, taken, not taken) is predicted without a miss once 16 outcomes have been recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request present |
| lkp_pc | input | AW | Address of the branch being looked up |
| lkp_tgt | input | AW | Target address of that branch |
| lkp_hint | input | 8 | Hint code: 8'h3E taken, 8'h2E not taken, others none |
| pred_valid | output | 1 | Prediction present (mirrors lkp_valid) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_from_hist | output | 1 | 1 when the guess came from a table slot |
| upd_valid | input | 1 | Resolved branch present |
| upd_pc | input | AW | Address of the resolved branch |
| upd_tgt | input | AW | Target of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
Prediction outputs depend combinationally on the lookup inputs and the table state. They are therefore due in the same cycle as the lookup. The bench drives lookups just after a rising edge and samples them at the following falling edge.

An update changes the table at the next rising edge. Its effect is therefore checked by a lookup issued in a later cycle. The exception is the same-cycle case in R10, which is sampled in its own cycle.

The scoreboard queues one expectation per lookup, in issue order. It compares each expectation in the cycle in which the lookup is presented.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam logic [7:0] HINT_FORCE_TAKEN = 8'h3E;
  localparam logic [7:0] HINT_FORCE_NOT   = 8'h2E;
  localparam int unsigned HINT_W          = 8;
endpackage

// File: rtl/bp_static_rule.sv
module bp_static_rule
  import bp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     tgt,
  input  logic [HINT_W-1:0] hint,
  output logic              taken
);
  logic backward;
  assign backward = (tgt <= pc);

  always_comb begin
    unique case (hint)
      HINT_FORCE_TAKEN: taken = 1'b1;
      HINT_FORCE_NOT:   taken = 1'b0;
      default:          taken = backward;
    endcase
  end
endmodule

// File: rtl/bp_tag_match.sv
module bp_tag_match #(
  parameter int unsigned AW      = 32,
  parameter int unsigned N_SLOTS = 8,
  localparam int unsigned IW     = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0][AW-1:0] tags,
  input  logic [N_SLOTS-1:0]         vld,
  input  logic [AW-1:0]              key,
  output logic                       hit,
  output logic [IW-1:0]              idx
);
  logic [N_SLOTS-1:0] match;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
    assign match[g] = vld[g] && (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (match[i]) idx = IW'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/bp_history_table.sv
module bp_history_table #(
  parameter int unsigned AW      = 32,
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned HL      = 16,
  localparam int unsigned IW     = $clog2(N_SLOTS),
  localparam int unsigned PW     = $clog2(HL)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       upd_valid,
  input  logic [AW-1:0]              upd_pc,
  input  logic                       upd_taken,
  input  logic                       upd_init,
  input  logic                       upd_hit,
  input  logic [IW-1:0]              upd_idx,
  output logic [N_SLOTS-1:0][AW-1:0] tags,
  output logic [N_SLOTS-1:0]         vld,
  output logic [N_SLOTS-1:0][HL-1:0] hist,
  output logic [N_SLOTS-1:0][PW-1:0] pos
);
  logic [IW-1:0] alloc_ptr;
  logic [HL-1:0] fresh;

  // new slot: rule direction everywhere, outcome at position 0
  always_comb begin
    fresh    = {HL{upd_init}};
    fresh[0] = upd_taken;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      alloc_ptr <= '0;
    end else if (upd_valid) begin
      if (upd_hit) begin
        hist[upd_idx][pos[upd_idx]] <= upd_taken;
        pos[upd_idx]                <= pos[upd_idx] + 1'b1;
      end else begin
        tags[alloc_ptr] <= upd_pc;
        vld[alloc_ptr]  <= 1'b1;
        hist[alloc_ptr] <= fresh;
        pos[alloc_ptr]  <= PW'(1);
        alloc_ptr       <= (alloc_ptr == IW'(N_SLOTS - 1)) ? '0 : alloc_ptr + 1'b1;
      end
    end
  end

  // R1: reset leaves no slot in use
  p_reset_empty_r1: assert property (@(posedge clk) rst |=> (vld == '0));

  // R7: a missing update claims a slot holding its tag, position 1
  p_alloc_tag_r7: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_hit) |=>
      (vld[$past(alloc_ptr)] && tags[$past(alloc_ptr)] == $past(upd_pc)
       && pos[$past(alloc_ptr)] == PW'(1)));

  // R8: a hit writes the outcome at the old position
  p_write_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_hit) |=>
      (hist[$past(upd_idx)][$past(pos[upd_idx])] == $past(upd_taken)));

  // R8: a hit advances the position modulo HL
  p_step_pos_r8: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_hit) |=>
      (pos[$past(upd_idx)] == PW'($past(pos[upd_idx]) + 1'b1)));
endmodule

// File: rtl/bp_hybrid_predictor.sv
module bp_hybrid_predictor
  import bp_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned HL      = 16   // power of two
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lkp_valid,
  input  logic [AW-1:0]     lkp_pc,
  input  logic [AW-1:0]     lkp_tgt,
  input  logic [HINT_W-1:0] lkp_hint,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic              pred_from_hist,
  input  logic              upd_valid,
  input  logic [AW-1:0]     upd_pc,
  input  logic [AW-1:0]     upd_tgt,
  input  logic              upd_taken
);
  localparam int unsigned IW = $clog2(N_SLOTS);
  localparam int unsigned PW = $clog2(HL);

  logic [N_SLOTS-1:0][AW-1:0] tags;
  logic [N_SLOTS-1:0]         vld;
  logic [N_SLOTS-1:0][HL-1:0] hist;
  logic [N_SLOTS-1:0][PW-1:0] pos;

  logic          lk_hit, up_hit, lk_rule, up_rule, same_addr;
  logic [IW-1:0] lk_idx, up_idx;
  logic [PW-1:0] next_pos;

  bp_tag_match #(.AW(AW), .N_SLOTS(N_SLOTS)) u_lk_match (
    .tags(tags), .vld(vld), .key(lkp_pc), .hit(lk_hit), .idx(lk_idx));

  bp_tag_match #(.AW(AW), .N_SLOTS(N_SLOTS)) u_up_match (
    .tags(tags), .vld(vld), .key(upd_pc), .hit(up_hit), .idx(up_idx));

  bp_static_rule #(.AW(AW)) u_lk_rule (
    .pc(lkp_pc), .tgt(lkp_tgt), .hint(lkp_hint), .taken(lk_rule));

  bp_static_rule #(.AW(AW)) u_up_rule (
    .pc(upd_pc), .tgt(upd_tgt), .hint(HINT_W'(0)), .taken(up_rule));

  bp_history_table #(.AW(AW), .N_SLOTS(N_SLOTS), .HL(HL)) u_table (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_init(up_rule), .upd_hit(up_hit),
    .upd_idx(up_idx), .tags(tags), .vld(vld), .hist(hist), .pos(pos));

  assign same_addr = lkp_valid && upd_valid && (lkp_pc == upd_pc);
  assign next_pos  = pos[up_idx] + 1'b1;

  always_comb begin
    if (same_addr) begin
      // update goes first: lookup sees the post-update slot
      pred_from_hist = 1'b1;
      pred_taken     = up_hit ? hist[up_idx][next_pos] : up_rule;
    end else if (lk_hit) begin
      pred_from_hist = 1'b1;
      pred_taken     = hist[lk_idx][pos[lk_idx]];
    end else begin
      pred_from_hist = 1'b0;
      pred_taken     = lk_rule;
    end
  end

  assign pred_valid = lkp_valid;

  // R4: forcing hint on a miss yields taken
  p_hint_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && !lk_hit && !same_addr && lkp_hint == HINT_FORCE_TAKEN) |-> pred_taken);

  // R4: opposite hint on a miss yields not taken
  p_hint_not_r4: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && !lk_hit && !same_addr && lkp_hint == HINT_FORCE_NOT) |-> !pred_taken);

  // R6: a tag hit always reports history as the source
  p_hit_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && lk_hit) |-> pred_from_hist);
endmodule

// File: tb/bp_hybrid_predictor_test.sv
module bp_hybrid_predictor_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lkp_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [AW-1:0] lkp_pc = '0, lkp_tgt = '0, upd_pc = '0, upd_tgt = '0;
  logic [7:0] lkp_hint = '0;
  logic pred_valid, pred_taken, pred_from_hist;

  int n_checks = 0;
  int n_bad = 0;

  typedef struct {
    logic  t;
    logic  h;
    bit    care;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  bp_hybrid_predictor #(.AW(AW), .N_SLOTS(8), .HL(16)) uut (
    .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .lkp_tgt(lkp_tgt), .lkp_hint(lkp_hint), .pred_valid(pred_valid),
    .pred_taken(pred_taken), .pred_from_hist(pred_from_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_tgt(upd_tgt),
    .upd_taken(upd_taken));

  task automatic set_lkp(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                         input logic [7:0] hint, input logic t, input logic h,
                         input bit care, input string tag);
    exp_t e;
    lkp_valid = 1'b1; lkp_pc = pc; lkp_tgt = tgt; lkp_hint = hint;
    e.t = t; e.h = h; e.care = care; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic look(input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                      input logic [7:0] hint, input logic t, input logic h,
                      input bit care, input string tag);
    @(posedge clk); #1;
    upd_valid = 1'b0;
    set_lkp(pc, tgt, hint, t, h, care, tag);
  endtask

  task automatic upd(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input logic t);
    @(posedge clk); #1;
    lkp_valid = 1'b0;
    upd_valid = 1'b1; upd_pc = pc; upd_tgt = tgt; upd_taken = t;
  endtask

  task automatic both(input logic [AW-1:0] pc, input logic [AW-1:0] tgt, input logic t,
                      input logic et, input logic eh, input string tag);
    @(posedge clk); #1;
    upd_valid = 1'b1; upd_pc = pc; upd_tgt = tgt; upd_taken = t;
    set_lkp(pc, tgt, 8'h00, et, eh, 1'b1, tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    lkp_valid = 1'b0; upd_valid = 1'b0;
  endtask

  // monitor: compare each presented prediction with the queued expectation
  always @(negedge clk) begin
    if (!rst && pred_valid) begin
      if (sb.size() == 0) begin
        n_checks++; n_bad++;
        $display("FAIL R11: prediction with no expectation queued");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.care) begin
          n_checks++;
          if (pred_taken !== e.t || pred_from_hist !== e.h) begin
            n_bad++;
            $display("FAIL %s: taken/hist actual=%b/%b expected=%b/%b",
                     e.tag, pred_taken, pred_from_hist, e.t, e.h);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_checks++; n_bad++;
    $display("FAIL watchdog: run did not end, actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 + R3: empty table, backward branch
    look(32'h100, 32'h080, 8'h00, 1'b1, 1'b0, 1'b1, "R1_R3");
    look(32'h100, 32'h100, 8'h00, 1'b1, 1'b0, 1'b1, "R3");
    // R2: forward branch
    look(32'h100, 32'h180, 8'h00, 1'b0, 1'b0, 1'b1, "R2");
    // R4: hints on misses
    look(32'h100, 32'h180, 8'h3E, 1'b1, 1'b0, 1'b1, "R4");
    look(32'h100, 32'h080, 8'h2E, 1'b0, 1'b0, 1'b1, "R4");
    look(32'h100, 32'h180, 8'h55, 1'b0, 1'b0, 1'b1, "R4");

    // R7: claim slot for forward 0x200, outcome taken -> bit0=1, rest 0, pos 1
    upd(32'h200, 32'h300, 1'b1);
    // R5 + R6: hint 3E ignored on hit, bit1 = 0
    look(32'h200, 32'h300, 8'h3E, 1'b0, 1'b1, 1'b1, "R5_R6_R7");
    // R8: write bit1=1, then 14 zeros wrap position to 0
    upd(32'h200, 32'h300, 1'b1);
    for (int i = 0; i < 14; i++) upd(32'h200, 32'h300, 1'b0);
    look(32'h200, 32'h300, 8'h00, 1'b1, 1'b1, 1'b1, "R8");
    upd(32'h200, 32'h300, 1'b0);   // bit0=0, pos 1
    look(32'h200, 32'h300, 8'h2E, 1'b1, 1'b1, 1'b1, "R8_R5");
    // R10: update at pos1 with lookup in same cycle -> sees bit2 = 0
    both(32'h200, 32'h300, 1'b0, 1'b0, 1'b1, "R10");
    look(32'h200, 32'h300, 8'h00, 1'b0, 1'b1, 1'b1, "R6");
    // R10: same-cycle allocation of backward branch -> hit, rule fill 1
    both(32'h900, 32'h800, 1'b0, 1'b1, 1'b1, "R10");
    look(32'h900, 32'h800, 8'h00, 1'b1, 1'b1, 1'b1, "R7");

    // R9: fill remaining six slots, then evict earliest (0x200)
    for (int i = 0; i < 6; i++) upd(32'hA00 + 32'(i * 16), 32'hB80, 1'b0);
    upd(32'hB00, 32'hB40, 1'b0);
    look(32'h200, 32'h300, 8'h00, 1'b0, 1'b0, 1'b1, "R9");
    look(32'h900, 32'h800, 8'h00, 1'b1, 1'b1, 1'b1, "R9");
    upd(32'hB10, 32'hB40, 1'b0);
    look(32'h900, 32'h800, 8'h2E, 1'b0, 1'b0, 1'b1, "R9");

    // R11: no lookup -> no prediction
    idle();
    @(negedge clk);
    n_checks++;
    if (pred_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: pred_valid actual=%b expected=0", pred_valid);
    end

    // R12: 4-trip loop repeated six times; exact after 16 outcomes
    n = 0;
    for (int run = 0; run < 6; run++) begin
      for (int it = 0; it < 4; it++) begin
        logic o;
        o = (it < 3);
        look(32'hC00, 32'hBF0, 8'h00, o, 1'b1, (n >= 16), "R12");
        upd(32'hC00, 32'hBF0, o);
        n++;
      end
    end
    idle();
    idle();

    n_checks++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R11: pending expectations actual=%0d expected=0", sb.size());
    end

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule